// File: doc/BRIEF.md
# Event Counter Group with Set/Clear Register Views

This block holds a parameterised group of event counters, each advanced by its own single-cycle increment pulse. The pulses normally come from upstream event selection and stream filtering logic. All state sits behind a register port with 12-bit addresses and 64-bit data. Software reads and preloads the counters there. It sets up a per-counter event-type word and a match word, which are driven out on ports for the filter logic. It also controls three per-counter bitmaps: counting enable, interrupt enable and overflow status.

Each bitmap has two addresses. A write to one address sets the bits that carry a 1, and a write to the other clears them. Reading either address returns the live bitmap, so software never needs a read-modify-write to change one counter. A counter advances only while its own enable bit and the global run bit are both set. When it wraps past its maximum it raises its overflow bit. An interrupt line reports overflowed counters that have their interrupt enabled, once the interrupt output is switched on. A constant configuration word tells software the counter count and width. That width sets the spacing of the counters in the address map.

Top module: `evcnt_group`

## Requirements
- R1: After reset every counter, the three bitmaps, the global run bit and the interrupt-output bit read zero, and `irq` is low.
- R2: Counter n adds one at each clock edge where `ev_pulse[n]` is high, enable bit n is 1 and the global run bit (bit 0 at 0xE04) is 1. Otherwise it holds its value.
- R3: Counter n is read and written at address n×S. S is 8 when the counter width exceeds 32 bits and 4 otherwise. A write keeps only the low width bits of `wdata`. A write wins over a pulse in the same cycle.
- R4: A counter that advances from all-ones wraps to zero and sets its overflow bit.
- R5: The bitmaps are reached through address pairs: enable set/clear at 0xC00/0xC20, interrupt enable set/clear at 0xC40/0xC60, and overflow set/clear at 0xCC0/0xC80. A 1 in `wdata` bit n acts on counter n only, and 0 bits change nothing. Both addresses of a pair read the current bitmap. If a wrap and an overflow clear hit the same bit in the same cycle, the wrap wins.
- R6: `irq` is high while bit 0 at 0xE50 is 1 and some counter has both its overflow bit and its interrupt-enable bit set. It stays high until software clears those overflow bits, clears those enables, or turns the output off.
- R7: The word at 0xE00 reads the counter count minus one in bits 5:0 and the width minus one in bits 13:8. Bit 23 reads the shared-filter flag parameter, and bits 20 and 21 read 0.
- R8: 0xE20 returns supported-event flags 0 to 63 and 0xE28 returns flags 64 to 127, both taken from a parameter.
- R9: Event-type word n at 0x400+4n and match word n at 0xA00+4n are 32-bit read/write registers. They appear on `typ_cfg` and `mat_cfg` at bits [32n+31:32n].
- R10: Read data is on `rd_data` one cycle after `rd_en`. Unmapped or misaligned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | NUM_CTR | Per-counter increment pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the access |
| wdata | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| irq | output | 1 | Overflow interrupt, level |
| typ_cfg | output | 32*NUM_CTR | Event-type words, one per counter |
| mat_cfg | output | 32*NUM_CTR | Match words, one per counter |

## Verification
The assertions check four things on every cycle. A wrap always lands in the overflow bitmap, and no overflow bit rises without a wrap or a set write. Counters freeze while the global run bit is low and nothing writes them. A raised `irq` holds until one of the three release actions occurs. The bench scenarios cover what needs known values: counter addressing at the 8-byte stride, truncation of oversized writes, the configuration and supported-event words, and the read-back of the event-type and match words on their ports. They also show that zero bits in set/clear writes change nothing and that unmapped addresses are inert.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  localparam logic [11:0] ADR_TYP    = 12'h400;
  localparam logic [11:0] ADR_MAT    = 12'hA00;
  localparam logic [11:0] ADR_EN_S   = 12'hC00;
  localparam logic [11:0] ADR_EN_C   = 12'hC20;
  localparam logic [11:0] ADR_IE_S   = 12'hC40;
  localparam logic [11:0] ADR_IE_C   = 12'hC60;
  localparam logic [11:0] ADR_OV_C   = 12'hC80;
  localparam logic [11:0] ADR_OV_S   = 12'hCC0;
  localparam logic [11:0] ADR_CFG    = 12'hE00;
  localparam logic [11:0] ADR_CTL    = 12'hE04;
  localparam logic [11:0] ADR_SUP0   = 12'hE20;
  localparam logic [11:0] ADR_SUP1   = 12'hE28;
  localparam logic [11:0] ADR_IRQC   = 12'hE50;

  typedef enum logic [3:0] {
    RK_NONE, RK_CNT, RK_TYP, RK_MAT,
    RK_EN_S, RK_EN_C, RK_IE_S, RK_IE_C,
    RK_OV_S, RK_OV_C, RK_CFG, RK_CTL,
    RK_IRQC, RK_SUP0, RK_SUP1
  } reg_kind_e;

  // byte spacing of counter registers for a given counter width
  function automatic int ctr_stride(int w);
    return (w > 32) ? 8 : 4;
  endfunction

  // constant configuration word
  function automatic logic [31:0] cfg_word(int n, int w, bit gf);
    logic [31:0] v;
    v        = '0;
    v[5:0]   = 6'(n - 1);
    v[13:8]  = 6'(w - 1);
    v[23]    = gf;
    return v;
  endfunction

  // set/clear bitmap update; hardware set wins over a clear
  function automatic logic [63:0] bm_next(logic [63:0] q, logic [63:0] m,
                                          logic set_s, logic clr_s,
                                          logic [63:0] hw);
    return (q & ~(clr_s ? m : 64'd0)) | (set_s ? m : 64'd0) | hw;
  endfunction

endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
  import evcnt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int STRIDE  = 8,
  parameter int IW      = 3
) (
  input  logic [11:0]   addr,
  output reg_kind_e     kind,
  output logic [IW-1:0] idx
);

  localparam int CNT_END = NUM_CTR * STRIDE;
  localparam int TYP_BEG = int'(ADR_TYP);
  localparam int TYP_END = TYP_BEG + 4 * NUM_CTR;
  localparam int MAT_BEG = int'(ADR_MAT);
  localparam int MAT_END = MAT_BEG + 4 * NUM_CTR;

  int a;
  assign a = int'(addr);

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (a < CNT_END) begin
      if ((a % STRIDE) == 0) begin
        kind = RK_CNT;
        idx  = IW'(a / STRIDE);
      end
    end else if (a >= TYP_BEG && a < TYP_END) begin
      if (addr[1:0] == 2'b00) begin
        kind = RK_TYP;
        idx  = IW'((a - TYP_BEG) / 4);
      end
    end else if (a >= MAT_BEG && a < MAT_END) begin
      if (addr[1:0] == 2'b00) begin
        kind = RK_MAT;
        idx  = IW'((a - MAT_BEG) / 4);
      end
    end else begin
      case (addr)
        ADR_EN_S: kind = RK_EN_S;
        ADR_EN_C: kind = RK_EN_C;
        ADR_IE_S: kind = RK_IE_S;
        ADR_IE_C: kind = RK_IE_C;
        ADR_OV_S: kind = RK_OV_S;
        ADR_OV_C: kind = RK_OV_C;
        ADR_CFG:  kind = RK_CFG;
        ADR_CTL:  kind = RK_CTL;
        ADR_IRQC: kind = RK_IRQC;
        ADR_SUP0: kind = RK_SUP0;
        ADR_SUP1: kind = RK_SUP1;
        default:  kind = RK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/evcnt_bitmap.sv
module evcnt_bitmap
  import evcnt_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_stb,
  input  logic               clr_stb,
  input  logic [NUM_CTR-1:0] mask,
  input  logic [NUM_CTR-1:0] hw_set,
  output logic [NUM_CTR-1:0] q
);

  logic [63:0] nxt;
  assign nxt = bm_next(64'(q), 64'(mask), set_stb, clr_stb, 64'(hw_set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[NUM_CTR-1:0];
  end

endmodule

// File: rtl/evcnt_lane.sv
module evcnt_lane #(
  parameter int CTR_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTR_W-1:0] wval,
  input  logic             inc,
  output logic [CTR_W-1:0] cnt,
  output logic             wrap
);

  // a wrap only counts when no software write takes the cycle
  assign wrap = inc && !wr && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (wr)  cnt <= wval;
    else if (inc) cnt <= cnt + CTR_W'(1);
  end

endmodule

// File: rtl/evcnt_group.sv
module evcnt_group
  import evcnt_pkg::*;
#(
  parameter int           NUM_CTR     = 8,
  parameter int           CTR_W       = 48,
  parameter bit           GLOBAL_FILT = 1'b1,
  parameter logic [127:0] SUPP_EVT    = 128'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CTR-1:0]   ev_pulse,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [11:0]          addr,
  input  logic [63:0]          wdata,
  output logic [63:0]          rd_data,
  output logic                 irq,
  output logic [32*NUM_CTR-1:0] typ_cfg,
  output logic [32*NUM_CTR-1:0] mat_cfg
);

  localparam int STRIDE = ctr_stride(CTR_W);
  localparam int IW     = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  reg_kind_e       kind;
  logic [IW-1:0]   idx;

  logic [NUM_CTR-1:0] en_q, ie_q, ovf_q, wrap_vec, cnt_wr, typ_wr, mat_wr;
  logic [NUM_CTR-1:0] wmask;
  logic [CTR_W-1:0]   cnt_q [NUM_CTR];
  logic [CTR_W*NUM_CTR-1:0] cnt_flat;
  logic [31:0]        typ_q [NUM_CTR];
  logic [31:0]        mat_q [NUM_CTR];
  logic               glob_en, irq_ctl;

  // named write events, brought out for the checker
  logic en_s_stb, en_c_stb, ie_s_stb, ie_c_stb, ov_s_stb, ov_c_stb;
  logic ctl_wr, irqc_wr, any_cnt_wr, any_typ_wr, any_mat_wr;
  logic [10:0] wr_strb;

  evcnt_decode #(.NUM_CTR(NUM_CTR), .STRIDE(STRIDE), .IW(IW)) u_dec (
    .addr (addr),
    .kind (kind),
    .idx  (idx)
  );

  assign wmask    = wdata[NUM_CTR-1:0];
  assign en_s_stb = wr_en && (kind == RK_EN_S);
  assign en_c_stb = wr_en && (kind == RK_EN_C);
  assign ie_s_stb = wr_en && (kind == RK_IE_S);
  assign ie_c_stb = wr_en && (kind == RK_IE_C);
  assign ov_s_stb = wr_en && (kind == RK_OV_S);
  assign ov_c_stb = wr_en && (kind == RK_OV_C);
  assign ctl_wr   = wr_en && (kind == RK_CTL);
  assign irqc_wr  = wr_en && (kind == RK_IRQC);

  assign any_cnt_wr = |cnt_wr;
  assign any_typ_wr = |typ_wr;
  assign any_mat_wr = |mat_wr;
  assign wr_strb = {any_cnt_wr, any_typ_wr, any_mat_wr, en_s_stb, en_c_stb,
                    ie_s_stb, ie_c_stb, ov_s_stb, ov_c_stb, ctl_wr, irqc_wr};

  // per-counter lanes and configuration words
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign cnt_wr[i] = wr_en && (kind == RK_CNT) && (idx == IW'(i));
    assign typ_wr[i] = wr_en && (kind == RK_TYP) && (idx == IW'(i));
    assign mat_wr[i] = wr_en && (kind == RK_MAT) && (idx == IW'(i));

    evcnt_lane #(.CTR_W(CTR_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (cnt_wr[i]),
      .wval (wdata[CTR_W-1:0]),
      .inc  (ev_pulse[i] && en_q[i] && glob_en),
      .cnt  (cnt_q[i]),
      .wrap (wrap_vec[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        typ_q[i] <= '0;
        mat_q[i] <= '0;
      end else begin
        if (typ_wr[i]) typ_q[i] <= wdata[31:0];
        if (mat_wr[i]) mat_q[i] <= wdata[31:0];
      end
    end

    assign cnt_flat[i*CTR_W +: CTR_W] = cnt_q[i];
    assign typ_cfg[i*32 +: 32]        = typ_q[i];
    assign mat_cfg[i*32 +: 32]        = mat_q[i];
  end

  evcnt_bitmap #(.NUM_CTR(NUM_CTR)) u_en (
    .clk(clk), .rst_n(rst_n), .set_stb(en_s_stb), .clr_stb(en_c_stb),
    .mask(wmask), .hw_set('0), .q(en_q)
  );

  evcnt_bitmap #(.NUM_CTR(NUM_CTR)) u_ie (
    .clk(clk), .rst_n(rst_n), .set_stb(ie_s_stb), .clr_stb(ie_c_stb),
    .mask(wmask), .hw_set('0), .q(ie_q)
  );

  evcnt_bitmap #(.NUM_CTR(NUM_CTR)) u_ovf (
    .clk(clk), .rst_n(rst_n), .set_stb(ov_s_stb), .clr_stb(ov_c_stb),
    .mask(wmask), .hw_set(wrap_vec), .q(ovf_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      irq_ctl <= 1'b0;
    end else begin
      if (ctl_wr)  glob_en <= wdata[0];
      if (irqc_wr) irq_ctl <= wdata[0];
    end
  end

  assign irq = irq_ctl && |(ovf_q & ie_q);

  // read path
  logic [63:0] rd_mux;
  always_comb begin
    case (kind)
      RK_CNT:           rd_mux = 64'(cnt_q[idx]);
      RK_TYP:           rd_mux = 64'(typ_q[idx]);
      RK_MAT:           rd_mux = 64'(mat_q[idx]);
      RK_EN_S, RK_EN_C: rd_mux = 64'(en_q);
      RK_IE_S, RK_IE_C: rd_mux = 64'(ie_q);
      RK_OV_S, RK_OV_C: rd_mux = 64'(ovf_q);
      RK_CFG:           rd_mux = 64'(cfg_word(NUM_CTR, CTR_W, GLOBAL_FILT));
      RK_CTL:           rd_mux = 64'(glob_en);
      RK_IRQC:          rd_mux = 64'(irq_ctl);
      RK_SUP0:          rd_mux = SUPP_EVT[63:0];
      RK_SUP1:          rd_mux = SUPP_EVT[127:64];
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: rtl/evcnt_group_chk.sv
module evcnt_group_chk #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 48
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     irq,
  input logic [NUM_CTR-1:0]       ovf_q,
  input logic [NUM_CTR-1:0]       wrap_vec,
  input logic [NUM_CTR-1:0]       wmask,
  input logic                     ov_s_stb,
  input logic                     ov_c_stb,
  input logic                     ie_c_stb,
  input logic                     irqc_wr,
  input logic                     glob_en,
  input logic                     any_cnt_wr,
  input logic [CTR_W*NUM_CTR-1:0] cnt_flat,
  input logic [10:0]              wr_strb
);

  // R4: every wrap shows up in the overflow bitmap
  a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  // R5: an overflow bit rises only from a wrap or a set write
  a_r5_no_spurious_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_q & ~$past(ovf_q) & ~$past(wrap_vec)
               & ~($past(ov_s_stb) ? $past(wmask) : '0)) == '0));

  // R5: clear write drops the addressed bits unless a wrap hit them
  a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ov_c_stb |=> ((ovf_q & $past(wmask & ~wrap_vec)) == '0));

  // R2: frozen counters while the global run bit is low
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !any_cnt_wr) |=> $stable(cnt_flat));

  // R6: interrupt holds until a release action
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ov_c_stb && !ie_c_stb && !irqc_wr) |=> irq);

  // R10: one write reaches at most one register
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strb));

endmodule

bind evcnt_group evcnt_group_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .ovf_q      (ovf_q),
  .wrap_vec   (wrap_vec),
  .wmask      (wmask),
  .ov_s_stb   (ov_s_stb),
  .ov_c_stb   (ov_c_stb),
  .ie_c_stb   (ie_c_stb),
  .irqc_wr    (irqc_wr),
  .glob_en    (glob_en),
  .any_cnt_wr (any_cnt_wr),
  .cnt_flat   (cnt_flat),
  .wr_strb    (wr_strb)
);

// File: tb/tb_evcnt_group.sv
module tb_evcnt_group;

  localparam int N  = 8;
  localparam int W  = 48;
  localparam int ST = (W > 32) ? 8 : 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    ev_pulse = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]     addr = '0;
  logic [63:0]     wdata = '0;
  logic [63:0]     rd_data;
  logic            irq;
  logic [32*N-1:0] typ_cfg, mat_cfg;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evcnt_group #(.NUM_CTR(N), .CTR_W(W), .GLOBAL_FILT(1'b1), .SUPP_EVT(128'hFF)) dut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq),
    .typ_cfg(typ_cfg), .mat_cfg(mat_cfg)
  );

  typedef struct { logic [63:0] exp; string tag; } exp_t;
  exp_t sb_q [$];
  logic rd_seen = 1'b0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: read result is registered at the edge after rd_en
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      if (sb_q.size() == 0) check("scoreboard empty", 64'd1, 64'd0);
      else begin
        e = sb_q.pop_front();
        check(e.tag, rd_data, e.exp);
      end
    end
  end

  // driver tasks, entered and left at a falling edge
  task automatic wr(logic [11:0] a, logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [63:0] exp, string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] m, int times);
    for (int k = 0; k < times; k++) begin
      ev_pulse = m;
      @(negedge clk);
      ev_pulse = '0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 64'(irq), 64'd0);
    rd(12'h000, 64'd0, "R1 counter0");
    rd(12'hC00, 64'd0, "R1 enable map");
    rd(12'hCC0, 64'd0, "R1 overflow map");
    rd(12'hE04, 64'd0, "R1 run bit");
    // R7 configuration word: 7 counters-1, width-1 = 47, shared filter
    rd(12'hE00, 64'h0080_2F07, "R7 config");
    // R8 supported events
    rd(12'hE20, 64'hFF, "R8 events low");
    rd(12'hE28, 64'd0, "R8 events high");

    // R5 set enables for 0 and 2, read through clear address
    wr(12'hC00, 64'h5);
    rd(12'hC20, 64'h5, "R5 enable via clear addr");
    // R2 run bit off: no counting
    pulse(8'h01, 2);
    rd(12'h000, 64'd0, "R2 no count when run off");
    wr(12'hE04, 64'd1);
    pulse(8'h03, 3);
    rd(12'h000, 64'd3, "R2 counter0 counted");
    rd(12'h008, 64'd0, "R2 counter1 disabled");

    // R3 addressing and truncation
    wr(12'h008, 64'h1234_5678_9ABC);
    rd(12'h008, 64'h1234_5678_9ABC, "R3 counter1 readback");
    wr(12'(3*ST), 64'hFFFF_1111_2222_3333);
    rd(12'(3*ST), 64'h1111_2222_3333, "R3 truncated write");

    // R4 wrap
    wr(12'(2*ST), 64'hFFFF_FFFF_FFFF);
    pulse(8'h04, 1);
    rd(12'(2*ST), 64'd0, "R4 wrapped to zero");
    rd(12'hCC0, 64'h4, "R4 overflow bit");
    rd(12'hC80, 64'h4, "R5 overflow via clear addr");

    // R6 interrupt
    wr(12'hC40, 64'h4);
    check("R6 irq gated by output bit", 64'(irq), 64'd0);
    wr(12'hE50, 64'd1);
    check("R6 irq raised", 64'(irq), 64'd1);
    wr(12'hC80, 64'h0);
    check("R5 zero clear keeps irq", 64'(irq), 64'd1);
    wr(12'hC80, 64'h4);
    check("R6 irq dropped after clear", 64'(irq), 64'd0);

    // R5 software set of overflow, interrupt enable clear
    wr(12'hCC0, 64'h10);
    rd(12'hC80, 64'h10, "R5 overflow set");
    check("R6 no irq without enable", 64'(irq), 64'd0);
    wr(12'hC60, 64'h4);
    rd(12'hC40, 64'd0, "R5 irq enable cleared");
    wr(12'hC20, 64'h1);
    pulse(8'h01, 2);
    rd(12'h000, 64'd3, "R5 cleared enable stops count");
    rd(12'hC00, 64'h4, "R5 other enable kept");

    // R9 configuration words
    wr(12'h408, 64'h2000_0001);
    wr(12'hA0C, 64'h42);
    rd(12'h408, 64'h2000_0001, "R9 type readback");
    check("R9 type port", 64'(typ_cfg[2*32 +: 32]), 64'h2000_0001);
    check("R9 match port", 64'(mat_cfg[3*32 +: 32]), 64'h42);

    // R10 unmapped
    wr(12'(N*ST), 64'hABCD);
    rd(12'(N*ST), 64'd0, "R10 beyond last counter");
    rd(12'h004, 64'd0, "R10 misaligned counter");
    rd(12'hF00, 64'd0, "R10 unmapped");
    rd(12'h000, 64'd3, "R10 counter0 untouched");

    // R3 write wins over a pulse in the same cycle
    wr(12'hC00, 64'h1);
    ev_pulse = 8'h01; wr_en = 1'b1; addr = 12'h000; wdata = 64'd100;
    @(negedge clk);
    ev_pulse = '0; wr_en = 1'b0;
    rd(12'h000, 64'd100, "R3 write over pulse");
    pulse(8'h01, 1);
    rd(12'h000, 64'd101, "R2 count after write");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule